// File: doc/BRIEF.md
# Condition-Field Test Packer

The block runs one single-bit test per element over a run of 4-bit condition fields and packs the resulting bits into 64-bit integer register images. Each test selects some bits of a field with a mask and compares them with a per-bit polarity pattern. In "any" mode the result is 1 when at least one selected bit agrees with its polarity bit. In "all" mode the result is 1 when every selected bit agrees. The block fetches one field per clock through a read port into the condition register. It emits whole-register write requests for an integer register file that sits outside the block.

A start pulse captures the whole configuration: the element count, the first source field, whether the source steps through fields or stays on one, whether the destination is a run of registers or a single register, a 2-bit packing code, the mask, the polarity pattern, the test mode and a reduction enable. In the stepping-destination case the packing code, not the integer width, sets how many results share one register. In the single-register case the results form a bitmask in one register. Successive results for the same register are merged inside the block, and each register is written exactly once, with no read of its old value.

Top module: `cr_test_packer`

## Requirements
- R1: After synchronous active-low reset, busy, done and wr_valid are all low.
- R2: For field bits f, mask m and polarity p, agree = ~(f ^ p) & m (bit 0 of rd_data is field bit 0). The result is (agree != 0) when any_mode=1 and (agree == m) when any_mode=0, so an all-zero mask gives 1 in all mode and 0 in any mode.
- R3: Element i reads field src_field+i modulo 8 when src_vec=1, and reads field src_field for every element when src_vec=0.
- R4: With dst_vec=1 and pack_code c, k = 2^c results share a register (c=0:1, 1:2, 2:4, 3:8). Result i is bit (i mod k) of register (dst_reg + i/k) modulo 32, and every bit at position k and above is zero.
- R5: When vl is not a multiple of k, the final partly filled register is still written, and its unused bits are zero.
- R6: With dst_vec=0 and reduce_en=1, result i is bit i of register dst_reg. A single write carries all vl results, and all bits at position vl and above are zero (vl up to 64).
- R7: With dst_vec=0 and reduce_en=0, only element 0 is tested. One write to dst_reg carries its result in bit 0.
- R8: A start seen while idle sets busy in the next cycle, and one element is then tested per cycle. A register's write appears in the cycle after its last element is tested. done pulses for one cycle together with the final write, and busy is low in that cycle.
- R9: A start with vl=0 gives a done pulse in the next cycle with no write and no busy.
- R10: While busy, start and changes on every configuration input have no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Captures the configuration when the block is idle |
| vl | input | 7 | Element count, 0 to 64 |
| src_field | input | 3 | First (or only) source field index |
| src_vec | input | 1 | 1: source field steps per element |
| dst_vec | input | 1 | 1: destination register steps per k results |
| pack_code | input | 2 | Results per register: 1, 2, 4 or 8 |
| dst_reg | input | 5 | First (or only) destination register index |
| fld_mask | input | 4 | Selects the field bits that take part in the test |
| fld_map | input | 4 | Polarity each selected bit is compared against |
| any_mode | input | 1 | 1: any-agree test, 0: all-agree test |
| reduce_en | input | 1 | Lets a single-register destination continue past element 0 |
| rd_field | output | 3 | Condition field index being read |
| rd_data | input | 4 | Contents of field rd_field, same cycle |
| busy | output | 1 | Elements are being tested |
| wr_valid | output | 1 | Write request valid |
| wr_idx | output | 5 | Destination register index |
| wr_data | output | 64 | Full register image to write |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
Runs use all four packing codes, with element counts that both fill and underfill the last register. This separates the per-register grouping from the bit offset inside a register and shows the tail write. Stepping and fixed sources are run over fields with distinct contents, so a wrong field index gives a wrong bit. Both test modes are used with masks that partly agree, fully agree and are empty. The single-register cases with and without reduction are compared with a wrapping destination base and with an empty run. A start held high while configuration inputs toggle shows that a run in progress ignores both, and that a new run is accepted exactly at the done cycle.

// File: rtl/cr_pack_pkg.sv
// Shared definitions for the condition-field test packer.
// Assumes a 2-bit packing code whose value is the log2 of the
// number of results that share one destination register.
package cr_pack_pkg;

    typedef enum logic [1:0] {
        PK_ONE   = 2'd0,
        PK_TWO   = 2'd1,
        PK_FOUR  = 2'd2,
        PK_EIGHT = 2'd3
    } pack_code_e;

    localparam int unsigned CP_XLEN   = 64;
    localparam int unsigned CP_FLD_W  = 4;
    localparam int unsigned CP_NFIELD = 8;
    localparam int unsigned CP_NREG   = 32;
    localparam int unsigned CP_VL_MAX = 64;

endpackage

// File: rtl/cp_field_test.sv
// Single-bit test of one condition field: the masked bits are compared with
// a polarity pattern and reduced to one result by an any or all rule.
// Assumes: purely combinational, the field arrives in the same cycle.
module cp_field_test #(
    parameter int unsigned FLD_W = 4
) (
    input  logic [FLD_W-1:0] fld,
    input  logic [FLD_W-1:0] mask,
    input  logic [FLD_W-1:0] polarity,
    input  logic             any_mode,
    output logic             hit
);

    logic [FLD_W-1:0] agree;

    // Reduce the per-bit agreement to a single result
    always_comb begin
        agree = ~(fld ^ polarity) & mask;
        if (any_mode) begin
            hit = |agree;
        end else begin
            hit = (agree == mask);
        end
    end

endmodule

// File: rtl/cp_slot_map.sv
// Maps an element number onto a destination register and a bit position.
// In stepping mode k = 2^code results share a register. In single-register
// mode the element number itself is the bit position.
// Assumes: the register index wraps modulo 2^RIDX_W.
module cp_slot_map
    import cr_pack_pkg::*;
#(
    parameter int unsigned VL_W   = 7,
    parameter int unsigned RIDX_W = 5,
    parameter int unsigned POS_W  = 6
) (
    input  logic [VL_W-1:0]   elem,
    input  logic              dst_vec,
    input  pack_code_e        code,
    input  logic [RIDX_W-1:0] base_reg,
    output logic [RIDX_W-1:0] reg_idx,
    output logic [POS_W-1:0]  bit_pos,
    output logic              group_end
);

    logic [VL_W-1:0] lane_mask;
    logic [VL_W-1:0] grp_num;
    logic [VL_W-1:0] lane;

    // Lane mask for the packing factor selected by the code
    always_comb begin
        unique case (code)
            PK_ONE:   lane_mask = VL_W'(0);
            PK_TWO:   lane_mask = VL_W'(1);
            PK_FOUR:  lane_mask = VL_W'(3);
            default:  lane_mask = VL_W'(7);
        endcase
    end

    // Register offset and lane derived from the element number
    always_comb begin
        grp_num = elem >> code;
        lane    = elem & lane_mask;
        if (dst_vec) begin
            reg_idx   = base_reg + RIDX_W'(grp_num);
            bit_pos   = POS_W'(lane);
            group_end = (lane == lane_mask);
        end else begin
            reg_idx   = base_reg;
            bit_pos   = POS_W'(elem);
            group_end = 1'b0;
        end
    end

endmodule

// File: rtl/cp_accum.sv
// Register-image accumulator: merges one result bit per cycle at a given
// position. It clears itself when the image is handed off or a run begins.
// Assumes: flush and clear are only meaningful while the run advances.
module cp_accum #(
    parameter int unsigned XLEN  = 64,
    parameter int unsigned POS_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    input  logic             flush,
    input  logic             hit,
    input  logic [POS_W-1:0] pos,
    output logic [XLEN-1:0]  merged
);

    logic [XLEN-1:0] acc_q;
    logic [XLEN-1:0] insert;

    // One-hot insertion vector, one comparator per bit
    for (genvar b = 0; b < XLEN; b++) begin : g_ins
        assign insert[b] = hit && (pos == POS_W'(b));
    end

    // Current image including this cycle's result
    always_comb begin
        merged = acc_q | insert;
    end

    // Hold the partial image between elements of the same register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clear) begin
            acc_q <= '0;
        end else if (advance) begin
            acc_q <= flush ? '0 : merged;
        end
    end

endmodule

// File: rtl/cr_test_packer.sv
// Condition-field test packer, top level. On start it captures the
// configuration, tests one field per clock through the read port, merges
// the results per destination register and issues whole-register writes.
// Assumes: the read port answers in the same cycle, the field count is a
// power of two, and vl does not exceed VL_MAX.
module cr_test_packer
    import cr_pack_pkg::*;
#(
    parameter int unsigned XLEN   = CP_XLEN,
    parameter int unsigned FLD_W  = CP_FLD_W,
    parameter int unsigned NFIELD = CP_NFIELD,
    parameter int unsigned NREG   = CP_NREG,
    parameter int unsigned VL_MAX = CP_VL_MAX,
    localparam int unsigned FIDX_W = $clog2(NFIELD),
    localparam int unsigned RIDX_W = $clog2(NREG),
    localparam int unsigned VL_W   = $clog2(VL_MAX + 1),
    localparam int unsigned POS_W  = $clog2(XLEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VL_W-1:0]   vl,
    input  logic [FIDX_W-1:0] src_field,
    input  logic              src_vec,
    input  logic              dst_vec,
    input  logic [1:0]        pack_code,
    input  logic [RIDX_W-1:0] dst_reg,
    input  logic [FLD_W-1:0]  fld_mask,
    input  logic [FLD_W-1:0]  fld_map,
    input  logic              any_mode,
    input  logic              reduce_en,
    output logic [FIDX_W-1:0] rd_field,
    input  logic [FLD_W-1:0]  rd_data,
    output logic              busy,
    output logic              wr_valid,
    output logic [RIDX_W-1:0] wr_idx,
    output logic [XLEN-1:0]   wr_data,
    output logic              done
);

    // Captured configuration
    logic [VL_W-1:0]   vl_eff_q;
    logic [FIDX_W-1:0] src_q;
    logic              src_vec_q;
    logic              dst_vec_q;
    pack_code_e        code_q;
    logic [RIDX_W-1:0] base_reg_q;
    logic [FLD_W-1:0]  mask_q;
    logic [FLD_W-1:0]  map_q;
    logic              any_q;

    // Run state and outputs
    logic              busy_q;
    logic [VL_W-1:0]   elem_q;
    logic              wr_valid_q;
    logic [RIDX_W-1:0] wr_idx_q;
    logic [XLEN-1:0]   wr_data_q;
    logic              done_q;

    logic              accept;
    logic [VL_W-1:0]   vl_eff;
    logic              last_elem;
    logic              hit;
    logic [RIDX_W-1:0] slot_reg;
    logic [POS_W-1:0]  slot_pos;
    logic              group_end;
    logic              flush;
    logic [XLEN-1:0]   merged;

    // Effective element count: a single-register run without reduction stops at one
    always_comb begin
        accept = start && !busy_q;
        if (vl == '0) begin
            vl_eff = '0;
        end else if (dst_vec || reduce_en) begin
            vl_eff = vl;
        end else begin
            vl_eff = VL_W'(1);
        end
    end

    // Source field index for the element under test
    always_comb begin
        if (src_vec_q) begin
            rd_field = src_q + FIDX_W'(elem_q);
        end else begin
            rd_field = src_q;
        end
    end

    cp_field_test #(
        .FLD_W    (FLD_W)
    ) u_test (
        .fld      (rd_data),
        .mask     (mask_q),
        .polarity (map_q),
        .any_mode (any_q),
        .hit      (hit)
    );

    cp_slot_map #(
        .VL_W      (VL_W),
        .RIDX_W    (RIDX_W),
        .POS_W     (POS_W)
    ) u_slot (
        .elem      (elem_q),
        .dst_vec   (dst_vec_q),
        .code      (code_q),
        .base_reg  (base_reg_q),
        .reg_idx   (slot_reg),
        .bit_pos   (slot_pos),
        .group_end (group_end)
    );

    // Hand off the image at a register boundary or at the end of the run
    always_comb begin
        last_elem = (elem_q == (vl_eff_q - VL_W'(1)));
        flush     = busy_q && (last_elem || group_end);
    end

    cp_accum #(
        .XLEN    (XLEN),
        .POS_W   (POS_W)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .advance (busy_q),
        .flush   (flush),
        .hit     (hit),
        .pos     (slot_pos),
        .merged  (merged)
    );

    // Capture the configuration when a run is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vl_eff_q   <= '0;
            src_q      <= '0;
            src_vec_q  <= 1'b0;
            dst_vec_q  <= 1'b0;
            code_q     <= PK_ONE;
            base_reg_q <= '0;
            mask_q     <= '0;
            map_q      <= '0;
            any_q      <= 1'b0;
        end else if (accept) begin
            vl_eff_q   <= vl_eff;
            src_q      <= src_field;
            src_vec_q  <= src_vec;
            dst_vec_q  <= dst_vec;
            code_q     <= pack_code_e'(pack_code);
            base_reg_q <= dst_reg;
            mask_q     <= fld_mask;
            map_q      <= fld_map;
            any_q      <= any_mode;
        end
    end

    // Sequence the elements and raise busy and done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            elem_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                elem_q <= '0;
                if (vl_eff == '0) begin
                    done_q <= 1'b1;
                end else begin
                    busy_q <= 1'b1;
                end
            end else if (busy_q) begin
                elem_q <= elem_q + VL_W'(1);
                if (last_elem) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    // Register the outgoing write request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid_q <= 1'b0;
            wr_idx_q   <= '0;
            wr_data_q  <= '0;
        end else begin
            wr_valid_q <= flush;
            if (flush) begin
                wr_idx_q  <= slot_reg;
                wr_data_q <= merged;
            end
        end
    end

    assign busy     = busy_q;
    assign wr_valid = wr_valid_q;
    assign wr_idx   = wr_idx_q;
    assign wr_data  = wr_data_q;
    assign done     = done_q;

endmodule

// File: rtl/cp_pack_chk.sv
// Port-level protocol checks for the condition-field test packer.
// Assumes it watches the top module's ports only, through the bind below.
module cp_pack_chk #(
    parameter int unsigned XLEN = 64,
    parameter int unsigned VL_W = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [VL_W-1:0] vl,
    input logic            dst_vec,
    input logic [1:0]      pack_code,
    input logic            busy,
    input logic            done,
    input logic            wr_valid,
    input logic [XLEN-1:0] wr_data
);

    logic       l_dvec;
    logic [1:0] l_code;
    logic [7:0] wr_cnt;
    logic [XLEN-1:0] high_part;

    // Remember the destination shape of the run and count its writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_dvec <= 1'b0;
            l_code <= 2'd0;
            wr_cnt <= '0;
        end else if (start && !busy) begin
            l_dvec <= dst_vec;
            l_code <= pack_code;
            wr_cnt <= '0;
        end else if (wr_valid && (wr_cnt != 8'hFF)) begin
            wr_cnt <= wr_cnt + 8'd1;
        end
    end

    // Bits of a write that lie above the packing factor
    always_comb begin
        high_part = wr_data >> (32'd1 << l_code);
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8
    write_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(busy));

    // R9
    empty_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (vl == '0)) |=> (done && !wr_valid && !busy));

    // R4
    pack_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && l_dvec) |-> (high_part == '0));

    // R7
    scalar_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !l_dvec) |-> (wr_cnt == 8'd0));

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

endmodule

bind cr_test_packer cp_pack_chk #(
    .XLEN      (XLEN),
    .VL_W      (VL_W)
) u_pack_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .vl        (vl),
    .dst_vec   (dst_vec),
    .pack_code (pack_code),
    .busy      (busy),
    .done      (done),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data)
);

// File: tb/cr_test_packer_test.sv
`timescale 1ns/1ps
// Bench for the condition-field test packer: a behavioural model builds the
// expected per-cycle outputs of each accepted run into queues, and every
// clock the ports are compared against the head of those queues.
module cr_test_packer_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [6:0]  vl;
    logic [2:0]  src_field;
    logic        src_vec;
    logic        dst_vec;
    logic [1:0]  pack_code;
    logic [4:0]  dst_reg;
    logic [3:0]  fld_mask;
    logic [3:0]  fld_map;
    logic        any_mode;
    logic        reduce_en;
    logic [2:0]  rd_field;
    logic [3:0]  rd_data;
    logic        busy;
    logic        wr_valid;
    logic [4:0]  wr_idx;
    logic [63:0] wr_data;
    logic        done;

    logic [3:0]  cr_mem [8];

    bit          q_busy [$];
    bit          q_val  [$];
    bit          q_done [$];
    logic [4:0]  q_idx  [$];
    logic [63:0] q_data [$];
    string       q_tag  [$];

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    assign rd_data = cr_mem[rd_field];

    cr_test_packer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .vl        (vl),
        .src_field (src_field),
        .src_vec   (src_vec),
        .dst_vec   (dst_vec),
        .pack_code (pack_code),
        .dst_reg   (dst_reg),
        .fld_mask  (fld_mask),
        .fld_map   (fld_map),
        .any_mode  (any_mode),
        .reduce_en (reduce_en),
        .rd_field  (rd_field),
        .rd_data   (rd_data),
        .busy      (busy),
        .wr_valid  (wr_valid),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .done      (done)
    );

    task automatic push_exp(bit b, bit v, bit d, logic [4:0] i, logic [63:0] x, string t);
        q_busy.push_back(b);
        q_val.push_back(v);
        q_done.push_back(d);
        q_idx.push_back(i);
        q_data.push_back(x);
        q_tag.push_back(t);
    endtask

    // Behavioural model of one run started with the current inputs
    task automatic push_model(string tag);
        int          eff;
        int          k;
        logic [63:0] acc;
        eff = (vl == 0) ? 0 : ((dst_vec || reduce_en) ? int'(vl) : 1);
        k   = 1 << pack_code;
        acc = '0;
        if (eff == 0) begin
            push_exp(1'b0, 1'b0, 1'b1, '0, '0, tag);
        end else begin
            push_exp(1'b1, 1'b0, 1'b0, '0, '0, tag);
            for (int e = 0; e < eff; e++) begin
                int         f;
                int         reg_i;
                int         pos;
                logic [3:0] agree;
                bit         res;
                bit         fl;
                f     = src_vec ? ((int'(src_field) + e) % 8) : int'(src_field);
                agree = ~(cr_mem[f] ^ fld_map) & fld_mask;
                res   = any_mode ? (agree != 4'd0) : (agree == fld_mask);
                if (dst_vec) begin
                    reg_i = (int'(dst_reg) + e / k) % 32;
                    pos   = e % k;
                    fl    = (e == eff - 1) || ((e % k) == k - 1);
                end else begin
                    reg_i = int'(dst_reg);
                    pos   = e;
                    fl    = (e == eff - 1);
                end
                if (res) acc[pos] = 1'b1;
                push_exp(e != eff - 1, fl, e == eff - 1, 5'(reg_i), acc, tag);
                if (fl) acc = '0;
            end
        end
    endtask

    // Compare the ports against the model for the current cycle
    task automatic compare(string idle_tag);
        bit          eb = 1'b0;
        bit          ev = 1'b0;
        bit          ed = 1'b0;
        logic [4:0]  ei = '0;
        logic [63:0] ex = '0;
        string       t  = idle_tag;
        bit          bad;
        if (q_busy.size() > 0) begin
            eb = q_busy.pop_front();
            ev = q_val.pop_front();
            ed = q_done.pop_front();
            ei = q_idx.pop_front();
            ex = q_data.pop_front();
            t  = q_tag.pop_front();
        end
        bad = (busy !== eb) || (done !== ed) || (wr_valid !== ev) ||
              (ev && ((wr_idx !== ei) || (wr_data !== ex)));
        n_cmp++;
        if (bad) begin
            n_bad++;
            $display("FAIL %s: busy=%b done=%b valid=%b idx=%0d data=%h expected busy=%b done=%b valid=%b idx=%0d data=%h",
                     t, busy, done, wr_valid, wr_idx, wr_data, eb, ed, ev, ei, ex);
        end
    endtask

    task automatic step(string idle_tag);
        @(negedge clk);
        compare(idle_tag);
    endtask

    task automatic launch(input logic [6:0] n, input logic [2:0] sf, input bit sv,
                          input bit dv, input logic [1:0] pc, input logic [4:0] dr,
                          input logic [3:0] msk, input logic [3:0] mp, input bit an,
                          input bit rd, input string tag);
        vl = n; src_field = sf; src_vec = sv; dst_vec = dv; pack_code = pc;
        dst_reg = dr; fld_mask = msk; fld_map = mp; any_mode = an; reduce_en = rd;
        start = 1'b1;
        push_model(tag);
        step(tag);
        start = 1'b0;
        while (q_busy.size() > 0) step(tag);
        step(tag);
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; vl = '0; src_field = '0; src_vec = 1'b0;
        dst_vec = 1'b0; pack_code = '0; dst_reg = '0; fld_mask = '0; fld_map = '0;
        any_mode = 1'b0; reduce_en = 1'b0;
        cr_mem[0] = 4'b0011; cr_mem[1] = 4'b1111; cr_mem[2] = 4'b0000; cr_mem[3] = 4'b0101;
        cr_mem[4] = 4'b1010; cr_mem[5] = 4'b0001; cr_mem[6] = 4'b1100; cr_mem[7] = 4'b0111;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: idle outputs after reset
        repeat (3) step("R1");

        // R2/R3/R4: stepping source, one result per register, all mode
        launch(7'd8, 3'd0, 1'b1, 1'b1, 2'd0, 5'd4, 4'b0011, 4'b0011, 1'b0, 1'b0, "R2/R4");
        // R2: any mode, polarity zero, partial mask
        launch(7'd8, 3'd0, 1'b1, 1'b1, 2'd0, 5'd4, 4'b1001, 4'b0000, 1'b1, 1'b0, "R2");
        // R2: empty mask in both modes
        launch(7'd3, 3'd2, 1'b1, 1'b1, 2'd0, 5'd0, 4'b0000, 4'b0110, 1'b0, 1'b0, "R2");
        launch(7'd3, 3'd2, 1'b1, 1'b1, 2'd0, 5'd0, 4'b0000, 4'b0110, 1'b1, 1'b0, "R2");
        // R4/R5: two per register, odd count leaves a partial register
        launch(7'd5, 3'd1, 1'b1, 1'b1, 2'd1, 5'd10, 4'b0101, 4'b0101, 1'b0, 1'b0, "R5");
        // R4: four per register, exact fill
        launch(7'd8, 3'd3, 1'b1, 1'b1, 2'd2, 5'd7, 4'b1100, 4'b0100, 1'b1, 1'b0, "R4");
        // R3/R5: eight per register with a fixed source field, partial tail
        launch(7'd11, 3'd3, 1'b0, 1'b1, 2'd3, 5'd2, 4'b0101, 4'b0101, 1'b0, 1'b0, "R3/R5");
        // R4: eight per register from a stepping source that wraps past field 7
        launch(7'd16, 3'd5, 1'b1, 1'b1, 2'd3, 5'd20, 4'b0011, 4'b0001, 1'b1, 1'b0, "R4");
        // R4: destination index wraps modulo 32
        launch(7'd4, 3'd6, 1'b1, 1'b1, 2'd0, 5'd30, 4'b1111, 4'b1100, 1'b0, 1'b0, "R4");
        // R6: single register with reduction, bits up to 19
        launch(7'd20, 3'd0, 1'b1, 1'b0, 2'd3, 5'd9, 4'b0001, 4'b0001, 1'b1, 1'b1, "R6");
        // R6: full 64-result bitmask
        launch(7'd64, 3'd1, 1'b1, 1'b0, 2'd0, 5'd1, 4'b0010, 4'b0010, 1'b0, 1'b1, "R6");
        // R7: single register without reduction stops after element 0
        launch(7'd5, 3'd1, 1'b1, 1'b0, 2'd0, 5'd17, 4'b1111, 4'b1111, 1'b0, 1'b0, "R7");
        launch(7'd5, 3'd2, 1'b1, 1'b0, 2'd2, 5'd18, 4'b1111, 4'b1111, 1'b0, 1'b0, "R7");
        // R9: empty run
        launch(7'd0, 3'd0, 1'b1, 1'b1, 2'd0, 5'd3, 4'b1111, 4'b0000, 1'b1, 1'b1, "R9");
        // R8: single element run, write and done together
        launch(7'd1, 3'd4, 1'b0, 1'b1, 2'd2, 5'd6, 4'b1000, 4'b1000, 1'b1, 1'b0, "R8");

        // R10: start held high and configuration toggling during runs
        vl = 7'd3; src_field = 3'd0; src_vec = 1'b1; dst_vec = 1'b1; pack_code = 2'd1;
        dst_reg = 5'd12; fld_mask = 4'b0011; fld_map = 4'b0001; any_mode = 1'b0;
        reduce_en = 1'b0;
        start = 1'b1;
        for (int c = 0; c < 14; c++) begin
            if (q_busy.size() == 0) push_model("R10");
            step("R10");
            fld_mask  = fld_mask ^ 4'b0110;
            fld_map   = fld_map ^ 4'b1001;
            pack_code = pack_code + 2'd1;
            src_field = src_field + 3'd3;
            any_mode  = ~any_mode;
        end
        start = 1'b0;
        while (q_busy.size() > 0) step("R10");
        repeat (2) step("R10");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule